// File: doc/BRIEF.md
# Huffman Bit Buffer with Context Save

This block keeps a 32-bit circular store of compressed bits in front of a Huffman decoder. A byte stream fills it two data bytes at a time, after it has removed the zero byte that follows every 0xFF data byte. The decoder sees a 16-bit window that starts at the next unread bit. Once it has matched a code, it tells the buffer how many bits to drop.

The decoder stage can be swapped out between MCUs, and its bit buffer is lost when that happens. To survive the swap, the buffer writes its whole state to three fixed words of an external 16-bit state memory on a save command. A restore command reads those words back, one read per clock, into the same positions. Decoding then continues from the same bit, with the same stuffing state, as if it had never stopped.

Top module: `huff_bitbuf`

## Requirements
- R1: During and right after an active-low reset the buffer holds no unread bits and the pointer is at position 31: win_valid=0, need_fill=1, in_ready=1, busy=0, mem_en=0.
- R2: Data bytes pair up in arrival order, first byte in the high half, into a 16-bit word that is appended after the unread bits. in_ready is low while a first byte is staged and 16 or more bits are unread.
- R3: A 0x00 byte accepted right after an accepted 0xFF data byte is discarded. Any other byte, including 0xFF after 0xFF, is data.
- R4: The next unread bit sits at buffer position ptr, and later bits sit at ptr-1, ptr-2 and so on, modulo 32. win_bits[15] is the bit at ptr and win_bits[0] the bit at ptr-15. win_valid is high exactly when no save or restore is running and at least 16 bits are unread.
- R5: cons_en with cons_len n (1 to 16) while win_valid is high drops n bits, so ptr moves down by n. cons_en has no effect while win_valid is low or when n is 0 or above 16.
- R6: need_fill is high exactly when fewer than 16 bits are unread.
- R7: A save writes three words in three consecutive cycles, at CTX_BASE (buffer bits 31..16), CTX_BASE+1 (bits 15..0) and CTX_BASE+2. The third word holds the stuffing flag in bit 15, the unread count in bits 13:8 and ptr in bits 4:0, with the other bits zero.
- R8: A save requested while a first byte is staged waits, and busy stays high, until the pair is complete. While it waits, in_ready is low unless a first byte is staged, and consuming still works.
- R9: A restore reads CTX_BASE, CTX_BASE+1 and CTX_BASE+2 in three consecutive cycles. It loads the returned words one cycle after each read, so the state is rebuilt in the fourth cycle. Any staged first byte is dropped, and the window and stream then continue bit for bit from the saved point.
- R10: During a save or restore, in_ready and win_valid are low and busy is high. Commands that arrive then are ignored. A save wins over a restore in the same cycle, and a restore is ignored while a save is waiting.
- R11: mem_en is high only during the three save writes and the three restore reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Stream byte accepted this cycle when valid |
| win_valid | output | 1 | Window holds 16 unread bits |
| win_bits | output | 16 | Next 16 unread bits, oldest in bit 15 |
| cons_en | input | 1 | Drop bits this cycle |
| cons_len | input | 5 | Number of bits to drop, 1 to 16 |
| need_fill | output | 1 | Fewer than 16 unread bits |
| save_req | input | 1 | Start a context save |
| restore_req | input | 1 | Start a context restore |
| busy | output | 1 | Save waiting or save/restore running |
| mem_en | output | 1 | State memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW (10) | State memory word address |
| mem_wdata | output | 16 | Word written |
| mem_rdata | input | 16 | Word read, valid one cycle after the read |

## Verification
The hardest state to reach from the ports is a save request that arrives while a first byte is staged and the buffer already holds 16 or more unread bits. The stream is stalled and the save cannot start. The stimulus feeds bytes with no consumption until the model reports exactly that state, then pulses the save. It then checks that busy holds and intake stays closed, and drains the window with 16-bit consumes until the pair completes and the writes begin. Restores are tried both after a reset and over a live buffer, and the window is compared bit for bit afterwards.

// File: rtl/huff_bitbuf.sv
module huff_bitbuf #(
  parameter int AW = 10,
  parameter logic [AW-1:0] CTX_BASE = 'h220
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          win_valid,
  output logic [15:0]   win_bits,
  input  logic          cons_en,
  input  logic [4:0]    cons_len,
  output logic          need_fill,
  input  logic          save_req,
  input  logic          restore_req,
  output logic          busy,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int BW = 32;
  localparam int WW = 16;
  localparam int PW = $clog2(BW);
  localparam int FW = PW + 1;
  localparam logic [FW-1:0] HALF = FW'(WW);

  typedef enum logic [1:0] {S_IDLE, S_SAVE, S_LOAD} mode_t;

  mode_t          mode_q;
  logic [1:0]     step_q;
  logic [BW-1:0]  bits_q, bits_nx;
  logic [PW-1:0]  ptr_q, wr_pos;
  logic [FW-1:0]  fill_q, cons_amt;
  logic           have_hi_q, skip_q, pend_q;
  logic [7:0]     hi_q;
  logic           idle, take, drop, data_byte, push;
  logic [WW-1:0]  word;

  assign idle      = (mode_q == S_IDLE);
  assign busy      = !idle || pend_q;
  assign need_fill = (fill_q < HALF);
  assign win_valid = idle && !need_fill;
  assign in_ready  = idle && (!have_hi_q || need_fill) && (!pend_q || have_hi_q);

  for (genvar k = 0; k < WW; k++) begin : g_win
    assign win_bits[WW-1-k] = bits_q[ptr_q - PW'(k)];
  end

  assign take      = in_valid && in_ready;
  assign drop      = take && skip_q && (in_data == 8'h00);
  assign data_byte = take && !drop;
  assign push      = data_byte && have_hi_q;
  assign word      = {hi_q, in_data};
  assign wr_pos    = ptr_q - fill_q[PW-1:0];
  assign cons_amt  = (cons_en && win_valid && cons_len != '0 && {1'b0, cons_len} <= HALF)
                     ? {1'b0, cons_len} : '0;

  always_comb begin
    bits_nx = bits_q;
    if (push)
      for (int k = 0; k < WW; k++)
        bits_nx[wr_pos - PW'(k)] = word[WW-1-k];
  end

  assign mem_en   = (mode_q == S_SAVE) || (mode_q == S_LOAD && step_q != 2'd3);
  assign mem_we   = (mode_q == S_SAVE);
  assign mem_addr = CTX_BASE + AW'(step_q);

  always_comb begin
    case (step_q)
      2'd0:    mem_wdata = bits_q[BW-1:WW];
      2'd1:    mem_wdata = bits_q[WW-1:0];
      default: mem_wdata = {skip_q, 1'b0, fill_q, 3'b000, ptr_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= S_IDLE;
      step_q    <= '0;
      bits_q    <= '0;
      ptr_q     <= '1;
      fill_q    <= '0;
      have_hi_q <= 1'b0;
      hi_q      <= '0;
      skip_q    <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      case (mode_q)
        S_IDLE: begin
          bits_q <= bits_nx;
          ptr_q  <= ptr_q - cons_amt[PW-1:0];
          fill_q <= fill_q - cons_amt + (push ? HALF : '0);
          if (data_byte) begin
            have_hi_q <= !have_hi_q;
            if (!have_hi_q) hi_q <= in_data;
          end
          if (take) skip_q <= !drop && (in_data == 8'hFF);
          if ((save_req || pend_q) && !have_hi_q) begin
            mode_q <= S_SAVE;
            step_q <= '0;
            pend_q <= 1'b0;
          end else if (save_req) begin
            pend_q <= 1'b1;
          end else if (restore_req && !pend_q) begin
            mode_q <= S_LOAD;
            step_q <= '0;
          end
        end
        S_SAVE: begin
          step_q <= step_q + 1'b1;
          if (step_q == 2'd2) mode_q <= S_IDLE;
        end
        S_LOAD: begin
          step_q <= step_q + 1'b1;
          case (step_q)
            2'd1: bits_q[BW-1:WW] <= mem_rdata;
            2'd2: bits_q[WW-1:0]  <= mem_rdata;
            2'd3: begin
              skip_q    <= mem_rdata[15];
              fill_q    <= mem_rdata[13:8];
              ptr_q     <= mem_rdata[4:0];
              have_hi_q <= 1'b0;
              mode_q    <= S_IDLE;
            end
            default: ;
          endcase
        end
        default: mode_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/huff_bitbuf_chk.sv
module huff_bitbuf_chk #(
  parameter int AW = 10,
  parameter logic [AW-1:0] CTX_BASE = 'h220
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          win_valid,
  input logic          busy,
  input logic          save_req,
  input logic          restore_req,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [5:0]    fill_q
);
  localparam logic [AW-1:0] A1 = CTX_BASE + AW'(1);
  localparam logic [AW-1:0] A2 = CTX_BASE + AW'(2);

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= 6'd32);

  assert_save_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && mem_addr == CTX_BASE |=> mem_en && mem_we && mem_addr == A1);

  assert_save_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && mem_addr == A1 |=> mem_en && mem_we && mem_addr == A2);

  assert_restore_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_req && !busy && !save_req |=> mem_en && !mem_we && mem_addr == CTX_BASE);

  assert_read_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && !mem_we && mem_addr == A2 |=> !mem_en);

  assert_quiet_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !in_ready && !win_valid && busy);

  assert_addr_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr >= CTX_BASE && mem_addr <= A2);
endmodule

bind huff_bitbuf huff_bitbuf_chk #(.AW(AW), .CTX_BASE(CTX_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .win_valid(win_valid),
  .busy(busy), .save_req(save_req), .restore_req(restore_req),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .fill_q(fill_q)
);

// File: tb/huff_bitbuf_test.sv
module huff_bitbuf_test;
  localparam int CLK_PER = 10;
  localparam logic [9:0] BASE = 10'h220;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_ready, win_valid, cons_en = 0, need_fill;
  logic save_req = 0, restore_req = 0, busy, mem_en, mem_we;
  logic [7:0] in_data = 0;
  logic [15:0] win_bits, mem_wdata, mem_rdata = 0;
  logic [4:0] cons_len = 0;
  logic [9:0] mem_addr;

  int n_chk = 0, n_fail = 0;
  string ctx = "R1 reset";
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  huff_bitbuf uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .win_valid(win_valid), .win_bits(win_bits), .cons_en(cons_en), .cons_len(cons_len),
    .need_fill(need_fill), .save_req(save_req), .restore_req(restore_req), .busy(busy),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  logic [15:0] ram [1024];
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end

  // reference model
  logic [31:0] mb, sb;
  int mptr, mfill, mmode, mstep, sptr, sfill;
  bit mhh, mskip, mpend, sskip;
  logic [7:0] mhi;

  function automatic bit m_idle(); return mmode == 0; endfunction
  function automatic bit m_wv(); return m_idle() && mfill >= 16; endfunction
  function automatic bit m_busy(); return !m_idle() || mpend; endfunction
  function automatic bit m_rdy();
    return m_idle() && (!mhh || mfill < 16) && (!mpend || mhh);
  endfunction
  function automatic logic [15:0] m_win();
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = mb[(mptr - k) & 31];
    return w;
  endfunction

  task automatic model_reset();
    mb = 0; mptr = 31; mfill = 0; mmode = 0; mstep = 0;
    mhh = 0; mskip = 0; mpend = 0; mhi = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else case (mmode)
      0: begin
        automatic bit hh0 = mhh, pend0 = mpend;
        automatic int cons = (cons_en && m_wv() && cons_len >= 1 && cons_len <= 16) ? int'(cons_len) : 0;
        automatic bit take = in_valid && m_rdy();
        automatic bit drop = take && mskip && in_data == 8'h00;
        automatic bit dat = take && !drop;
        automatic bit push = dat && mhh;
        automatic logic [15:0] wd = {mhi, in_data};
        if (push) begin
          automatic int wr = mptr - mfill;
          for (int k = 0; k < 16; k++) mb[(wr - k) & 31] = wd[15-k];
        end
        mptr = (mptr - cons) & 31;
        mfill = mfill - cons + (push ? 16 : 0);
        if (dat) begin
          if (!hh0) mhi = in_data;
          mhh = !hh0;
        end
        if (take) mskip = !drop && in_data == 8'hFF;
        if ((save_req || pend0) && !hh0) begin mmode = 1; mstep = 0; mpend = 0; end
        else if (save_req) mpend = 1;
        else if (restore_req && !pend0) begin mmode = 2; mstep = 0; end
      end
      1: begin
        if (mstep == 0) begin sb = mb; sptr = mptr; sfill = mfill; sskip = mskip; end
        if (mstep == 2) mmode = 0;
        mstep++;
      end
      default: begin
        if (mstep == 3) begin
          mb = sb; mptr = sptr; mfill = sfill; mskip = sskip; mhh = 0; mmode = 0;
        end
        mstep++;
      end
    endcase
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!done) begin
      if (!rst_n) begin
        chk("R1 win_valid", win_valid, 0);
        chk("R1 need_fill", need_fill, 1);
        chk("R1 in_ready", in_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 mem_en", mem_en, 0);
      end else begin
        automatic bit e_en = (mmode == 1) || (mmode == 2 && mstep != 3);
        chk("R2 in_ready", in_ready, m_rdy());
        chk("R4 win_valid", win_valid, m_wv());
        if (m_wv()) chk("R4 win_bits", win_bits, m_win());
        chk("R6 need_fill", need_fill, mfill < 16);
        chk("R10 busy", busy, m_busy());
        chk("R11 mem_en", mem_en, e_en);
        if (e_en) begin
          chk("R7/R9 mem_we", mem_we, mmode == 1);
          chk("R7/R9 mem_addr", mem_addr, BASE + 10'(mstep));
          if (mmode == 1)
            chk("R7 mem_wdata", mem_wdata,
                mstep == 0 ? mb[31:16] : mstep == 1 ? mb[15:0]
                : {mskip, 1'b0, 6'(mfill), 3'b000, 5'(mptr)});
        end
      end
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog [%s] actual=running expected=finished", ctx);
    finish_up();
  end

  task automatic cyc(input int pv, input int pc, input int ffp);
    @(negedge clk);
    save_req = 0; restore_req = 0;
    in_valid = $urandom_range(99) < pv;
    if ($urandom_range(99) < ffp) in_data = 8'hFF;
    else if ($urandom_range(99) < ffp) in_data = 8'h00;
    else in_data = 8'($urandom);
    cons_en = m_wv() && $urandom_range(99) < pc;
    cons_len = 5'($urandom_range(16, 1));
  endtask

  task automatic cmd(input bit s, input bit r);
    @(negedge clk);
    in_valid = 0; cons_en = 0; save_req = s; restore_req = r;
  endtask

  task automatic run(input int n, input int pv, input int pc, input int ffp);
    for (int i = 0; i < n; i++) cyc(pv, pc, ffp);
  endtask

  task automatic settle();
    int guard = 0;
    while (m_busy() && guard < 200) begin cyc(80, 60, 10); guard++; end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    ctx = "R2 fill without consume";
    run(40, 90, 0, 5);
    ctx = "R4 R5 window and consume";
    run(1500, 70, 70, 5);
    ctx = "R5 zero and oversize length ignored";
    for (int i = 0; i < 40; i++) begin
      cyc(60, 0, 5);
      cons_en = 1; cons_len = (i % 2) ? 5'd0 : 5'd17 + 5'(i % 8);
    end
    ctx = "R3 unstuffing";
    run(1500, 80, 60, 35);

    ctx = "R8 deferred save";
    begin
      int g = 0;
      forever begin
        @(negedge clk);
        if ((mhh && mfill >= 16) || g > 500) break;
        save_req = 0; restore_req = 0;
        in_valid = 1; in_data = 8'($urandom_range(254, 1)); cons_en = 0;
        g++;
      end
    end
    save_req = 1; in_valid = 0; cons_en = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); save_req = 0; in_valid = 1; in_data = 8'h5A; cons_en = 0;
    end
    for (int i = 0; i < 40 && mmode == 0; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'h3C;
      cons_en = m_wv(); cons_len = 5'd16;
    end
    settle();

    ctx = "R9 restore after reset";
    run(100, 70, 70, 10);
    @(negedge clk); rst_n = 0; in_valid = 0; cons_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    cmd(0, 1);
    settle();
    run(600, 70, 70, 10);

    ctx = "R9 restore over live state";
    cmd(1, 0); settle();
    run(300, 70, 70, 10);
    cmd(0, 1); settle();
    run(400, 70, 70, 10);

    ctx = "R10 commands while busy";
    cmd(1, 0); cmd(0, 1); cmd(1, 1); settle();
    run(50, 70, 70, 10);
    cmd(0, 1); cmd(1, 0); settle();
    run(50, 70, 70, 10);
    cmd(1, 1); settle();
    run(300, 70, 70, 10);

    ctx = "R11 idle tail";
    run(20, 0, 0, 0);
    finish_up();
  end
endmodule